// File: doc/BRIEF.md
# Skip-Style Next-PC Unit

This block works out the next program counter for a 16-bit processor whose conditional control flow never branches. A conditional instruction tests two 16-bit operands. When the test holds, the PC moves past the following instruction, which is skipped. When the test fails, the PC moves on by one instruction as normal. Every instruction is two bytes long. A sequential step therefore adds 2 to the PC, and a skip adds 4.

A separate unconditional jump adds an 11-bit signed, sign-extended offset to the address of the jump instruction itself. All PC arithmetic wraps modulo 2^16.

The decision logic is purely combinational. The result appears on `next_pc`, and `taken` tells whether a skip or jump happened. The `REG_PC` parameter controls an optional PC register. When the register is present, it has two behaviours:
- It holds its value, or it loads `next_pc` on a clock edge where `step` is high.
- It returns to `RESET_PC` (0x0000 by default) while `rst_n` is low.

When the register is left out, `pc_q` simply follows `next_pc`.

Top module: `npc_unit`

## Requirements
- R1: With `op_sel` = 0 (sequential) or 3 (reserved, treated as sequential), `next_pc` = `pc_in` + 2 and `taken` = 0.
- R2: Condition code 0 (equal) holds when A == B. Code 1 (not equal) holds when A != B.
- R3: Code 2 (signed less-than) holds when A < B as two's complement numbers. Code 3 (signed greater-or-equal) is its complement. For example, 0x8000 < 0x0001 holds under code 2.
- R4: Code 4 (unsigned less-than) holds when A < B as unsigned numbers. Code 5 (unsigned greater-or-equal) is its complement. For example, 0x8000 < 0x0001 does not hold under code 4.
- R5: Code 6 (bit-test clear) holds when (A & B) == 0. Code 7 (bit-test set) holds when (A & B) != 0.
- R6: With `op_sel` = 1 (test), `taken` equals the selected condition. `next_pc` is `pc_in` + 4 when the condition holds and `pc_in` + 2 otherwise.
- R7: When `b_is_imm` = 1, operand B is `imm4` zero-extended to 16 bits, and `opnd_b` has no effect. When `b_is_imm` = 0, B is `opnd_b`.
- R8: With `op_sel` = 2 (jump), `next_pc` = `pc_in` + sign-extended `rel_off`, wrapped modulo 2^16, and `taken` = 1. The condition code and the operands have no effect.
- R9: With `REG_PC` = 1, `pc_q` reads `RESET_PC` while `rst_n` is low. Afterwards it takes the value of `next_pc` at each rising clock edge with `step` high, and holds at every other edge.
- R10: The +2 and +4 advances wrap modulo 2^16. For example, 0xFFFE + 2 = 0x0000 and 0xFFFE + 4 = 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional PC register |
| rst_n | input | 1 | Active-low reset of the PC register |
| step | input | 1 | Load `next_pc` into the PC register at the next edge |
| pc_in | input | 16 | Address of the current instruction |
| op_sel | input | 2 | 0 sequential, 1 test, 2 jump, 3 reserved (sequential) |
| cond | input | 3 | Condition code, used when `op_sel` = 1 |
| opnd_a | input | 16 | First comparison operand |
| opnd_b | input | 16 | Second comparison operand when it comes from a register |
| b_is_imm | input | 1 | Select the immediate as the second operand |
| imm4 | input | 4 | Unsigned immediate for the second operand |
| rel_off | input | 11 | Signed jump offset |
| next_pc | output | 16 | Computed next program counter |
| taken | output | 1 | High when a skip or jump occurs |
| pc_q | output | 16 | Registered PC, or `next_pc` when the register is left out |

## Verification
The bench targets operands whose sign bits differ, such as 0x8000 against 0x0001 and 0x7FFF against 0xFFFF. A design that reused the unsigned comparison for the signed codes, or the other way round, would skip the wrong way on exactly these pairs.

Several further cases are probed:
- Equal operands, which separate the less-than codes from the greater-or-equal codes.
- Bit-test masks with a single shared bit and with none.
- An immediate paired with a register value whose set bits would change the result. This exposes a sign-extended immediate or a mux that leaks `opnd_b`.
- Jumps with the most negative and most positive offsets, and advances across 0xFFFE. Both catch a zero-extended offset and a carry that escapes the 16-bit width.
- The register's hold behaviour, checked by moving `pc_in` while `step` is low.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        OP_SEQ  = 2'd0,
        OP_TEST = 2'd1,
        OP_JUMP = 2'd2,
        OP_RSVD = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_SLT  = 3'd2,
        CC_SGE  = 3'd3,
        CC_ULT  = 3'd4,
        CC_UGE  = 3'd5,
        CC_BCLR = 3'd6,
        CC_BSET = 3'd7
    } cond_e;

endpackage

// File: rtl/npc_opnd_sel.sv
module npc_opnd_sel #(
    parameter int W     = 16,
    parameter int IMM_W = 4
) (
    input  logic [W-1:0]     reg_b,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     opnd
);
    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    // zero extension: the immediate is always unsigned
    assign imm_ext = {{PAD_W{1'b0}}, imm};

    always_comb begin
        if (use_imm) opnd = imm_ext;
        else         opnd = reg_b;
    end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cond_e        cc,
    output logic         hold
);
    logic is_eq;
    logic is_slt;
    logic is_ult;
    logic any_common;

    always_comb begin
        is_eq      = (a == b);
        is_ult     = (a < b);
        is_slt     = ($signed(a) < $signed(b));
        any_common = |(a & b);
    end

    always_comb begin
        unique case (cc)
            CC_EQ:   hold = is_eq;
            CC_NE:   hold = !is_eq;
            CC_SLT:  hold = is_slt;
            CC_SGE:  hold = !is_slt;
            CC_ULT:  hold = is_ult;
            CC_UGE:  hold = !is_ult;
            CC_BCLR: hold = !any_common;
            CC_BSET: hold = any_common;
            default: hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int W      = 16,
    parameter int OFF_W  = 11,
    parameter int INSN_B = 2
) (
    input  logic [W-1:0]     pc,
    input  logic [OFF_W-1:0] off,
    output logic [W-1:0]     seq_pc,
    output logic [W-1:0]     skip_pc,
    output logic [W-1:0]     jump_pc
);
    localparam int          EXT_W   = W - OFF_W;
    localparam logic [W-1:0] ONE_INSN = W'(INSN_B);
    localparam logic [W-1:0] TWO_INSN = W'(2 * INSN_B);

    logic [W-1:0] off_ext;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};

    // all sums truncate to W bits: wrap modulo 2^W
    always_comb begin
        seq_pc  = pc + ONE_INSN;
        skip_pc = pc + TWO_INSN;
        jump_pc = pc + off_ext;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          OFF_W    = 11,
    parameter int          IMM_W    = 4,
    parameter int          INSN_B   = 2,
    parameter bit          REG_PC   = 1'b1,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [W-1:0]     pc_in,
    input  logic [1:0]       op_sel,
    input  logic [2:0]       cond,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic             b_is_imm,
    input  logic [IMM_W-1:0] imm4,
    input  logic [OFF_W-1:0] rel_off,
    output logic [W-1:0]     next_pc,
    output logic             taken,
    output logic [W-1:0]     pc_q
);
    op_kind_e     op;
    cond_e        cc;
    logic [W-1:0] b_eff;
    logic         cond_hold;
    logic [W-1:0] seq_pc;
    logic [W-1:0] skip_pc;
    logic [W-1:0] jump_pc;

    assign op = op_kind_e'(op_sel);
    assign cc = cond_e'(cond);

    npc_opnd_sel #(.W(W), .IMM_W(IMM_W)) u_opnd (
        .reg_b   (opnd_b),
        .use_imm (b_is_imm),
        .imm     (imm4),
        .opnd    (b_eff)
    );

    npc_cond_eval #(.W(W)) u_cond (
        .a    (opnd_a),
        .b    (b_eff),
        .cc   (cc),
        .hold (cond_hold)
    );

    npc_target #(.W(W), .OFF_W(OFF_W), .INSN_B(INSN_B)) u_tgt (
        .pc      (pc_in),
        .off     (rel_off),
        .seq_pc  (seq_pc),
        .skip_pc (skip_pc),
        .jump_pc (jump_pc)
    );

    always_comb begin
        unique case (op)
            OP_TEST: begin
                taken   = cond_hold;
                next_pc = cond_hold ? skip_pc : seq_pc;
            end
            OP_JUMP: begin
                taken   = 1'b1;
                next_pc = jump_pc;
            end
            OP_SEQ, OP_RSVD: begin
                taken   = 1'b0;
                next_pc = seq_pc;
            end
            default: begin
                taken   = 1'b0;
                next_pc = seq_pc;
            end
        endcase
    end

    generate
        if (REG_PC) begin : g_pc_reg
            logic [W-1:0] pc_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    pc_r <= W'(RESET_PC);
                else if (step) pc_r <= next_pc;
            end
            assign pc_q = pc_r;
        end else begin : g_pc_comb
            assign pc_q = next_pc;
        end
    endgenerate
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int          W        = 16,
    parameter int          OFF_W    = 11,
    parameter bit          REG_PC   = 1'b1,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic [W-1:0]     pc_in,
    input logic [1:0]       op_sel,
    input logic [W-1:0]     next_pc,
    input logic             taken,
    input logic [W-1:0]     pc_q
);
    // R1
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 || op_sel == 2'd3) |-> (next_pc == W'(pc_in + W'(2)) && !taken));

    // R6
    skip_distance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd1) |-> (next_pc == W'(pc_in + (taken ? W'(4) : W'(2)))));

    // R8
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd2) |-> taken);

    generate
        if (REG_PC) begin : g_reg_chk
            // R9
            pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> (pc_q == $past(next_pc)));

            // R9
            pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !step |=> $stable(pc_q));

            // R9
            always_comb begin
                if (!rst_n) begin
                    pc_reset_chk: assert final (pc_q == W'(RESET_PC));
                end
            end
        end
    endgenerate
endmodule

bind npc_unit npc_unit_chk #(
    .W(W), .OFF_W(OFF_W), .REG_PC(REG_PC), .RESET_PC(RESET_PC)
) u_npc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .pc_in   (pc_in),
    .op_sel  (op_sel),
    .next_pc (next_pc),
    .taken   (taken),
    .pc_q    (pc_q)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [15:0] pc_in = '0;
    logic [1:0]  op_sel = '0;
    logic [2:0]  cond = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        b_is_imm = 1'b0;
    logic [3:0]  imm4 = '0;
    logic [10:0] rel_off = '0;
    logic [15:0] next_pc;
    logic        taken;
    logic [15:0] pc_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .step(step), .pc_in(pc_in),
        .op_sel(op_sel), .cond(cond), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .b_is_imm(b_is_imm), .imm4(imm4), .rel_off(rel_off),
        .next_pc(next_pc), .taken(taken), .pc_q(pc_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit model_cond(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) < $signed(b);
            3'd3: return $signed(a) >= $signed(b);
            3'd4: return a < b;
            3'd5: return a >= b;
            3'd6: return (a & b) == 16'h0;
            default: return (a & b) != 16'h0;
        endcase
    endfunction

    task automatic test_op(input string req, input logic [15:0] pc, input logic [2:0] c,
                           input logic [15:0] a, input logic [15:0] b);
        bit h;
        op_sel = 2'd1; cond = c; pc_in = pc; opnd_a = a; opnd_b = b; b_is_imm = 1'b0;
        #1;
        h = model_cond(c, a, b);
        chk({req, " taken"}, {15'b0, taken}, {15'b0, h});
        chk({req, " next_pc"}, next_pc, pc + (h ? 16'd4 : 16'd2));
    endtask

    task automatic test_reset;
        #1;
        chk("R9 reset pc_q", pc_q, 16'h0000);
    endtask

    task automatic test_sequential;
        op_sel = 2'd0; pc_in = 16'h1234; opnd_a = 16'h5; opnd_b = 16'h5; #1;
        chk("R1 seq next_pc", next_pc, 16'h1236);
        chk("R1 seq taken", {15'b0, taken}, 16'h0);
        op_sel = 2'd3; cond = 3'd0; #1;
        chk("R1 rsvd next_pc", next_pc, 16'h1236);
        chk("R1 rsvd taken", {15'b0, taken}, 16'h0);
    endtask

    task automatic test_equality;
        test_op("R2 eq same", 16'h0100, 3'd0, 16'hA5A5, 16'hA5A5);
        test_op("R2 eq diff", 16'h0100, 3'd0, 16'hA5A5, 16'hA5A4);
        test_op("R2 ne same", 16'h0100, 3'd1, 16'h0000, 16'h0000);
        test_op("R2 ne diff", 16'h0100, 3'd1, 16'h8000, 16'h0000);
    endtask

    task automatic test_signed;
        test_op("R3 slt neg<pos", 16'h0200, 3'd2, 16'h8000, 16'h0001);
        test_op("R3 slt pos<neg", 16'h0200, 3'd2, 16'h7FFF, 16'hFFFF);
        test_op("R3 slt equal", 16'h0200, 3'd2, 16'h1234, 16'h1234);
        test_op("R3 sge equal", 16'h0200, 3'd3, 16'h1234, 16'h1234);
        test_op("R3 sge neg", 16'h0200, 3'd3, 16'h8000, 16'h0001);
        test_op("R3 sge pos", 16'h0200, 3'd3, 16'h7FFF, 16'hFFFF);
    endtask

    task automatic test_unsigned;
        test_op("R4 ult big", 16'h0300, 3'd4, 16'h8000, 16'h0001);
        test_op("R4 ult small", 16'h0300, 3'd4, 16'h0001, 16'h8000);
        test_op("R4 ult equal", 16'h0300, 3'd4, 16'hFFFF, 16'hFFFF);
        test_op("R4 uge equal", 16'h0300, 3'd5, 16'hFFFF, 16'hFFFF);
        test_op("R4 uge big", 16'h0300, 3'd5, 16'h8000, 16'h0001);
        test_op("R4 uge small", 16'h0300, 3'd5, 16'h7FFF, 16'hFFFF);
    endtask

    task automatic test_bits;
        test_op("R5 bclr none", 16'h0400, 3'd6, 16'hF0F0, 16'h0F0F);
        test_op("R5 bclr one", 16'h0400, 3'd6, 16'hF0F0, 16'h0010);
        test_op("R5 bset one", 16'h0400, 3'd7, 16'h8001, 16'h8000);
        test_op("R5 bset none", 16'h0400, 3'd7, 16'h8001, 16'h7FFE);
    endtask

    task automatic test_skip_flags;
        test_op("R6 skip held", 16'h0500, 3'd0, 16'h0007, 16'h0007);
        test_op("R6 skip not held", 16'h0500, 3'd1, 16'h0007, 16'h0007);
    endtask

    task automatic test_immediate;
        op_sel = 2'd1; pc_in = 16'h0600; b_is_imm = 1'b1;
        cond = 3'd0; opnd_a = 16'h000F; imm4 = 4'hF; opnd_b = 16'hFFFF; #1;
        chk("R7 imm zext eq taken", {15'b0, taken}, 16'h1);
        chk("R7 imm zext eq next_pc", next_pc, 16'h0604);
        cond = 3'd7; opnd_a = 16'hFFF0; imm4 = 4'h8; opnd_b = 16'hFFFF; #1;
        chk("R7 imm ignores opnd_b", {15'b0, taken}, 16'h0);
        cond = 3'd2; opnd_a = 16'hFFFF; imm4 = 4'h8; #1;
        chk("R7 imm unsigned for slt", {15'b0, taken}, 16'h1);
        b_is_imm = 1'b0; cond = 3'd0; opnd_a = 16'h000F; opnd_b = 16'h000F; imm4 = 4'h0; #1;
        chk("R7 register operand", {15'b0, taken}, 16'h1);
    endtask

    task automatic test_jump;
        op_sel = 2'd2; cond = 3'd1; opnd_a = 16'h1; opnd_b = 16'h1;
        pc_in = 16'h1000; rel_off = 11'h400; #1;
        chk("R8 jump min offset", next_pc, 16'h0C00);
        chk("R8 jump taken", {15'b0, taken}, 16'h1);
        rel_off = 11'h3FF; #1;
        chk("R8 jump max offset", next_pc, 16'h13FF);
        pc_in = 16'h0002; rel_off = 11'h7FC; #1;
        chk("R8 jump wrap below zero", next_pc, 16'hFFFE);
        pc_in = 16'hFFF0; rel_off = 11'h020; #1;
        chk("R8 jump wrap above top", next_pc, 16'h0010);
    endtask

    task automatic test_wrap;
        op_sel = 2'd0; pc_in = 16'hFFFE; #1;
        chk("R10 seq wrap", next_pc, 16'h0000);
        test_op("R10 skip wrap", 16'hFFFE, 3'd0, 16'h0, 16'h0);
    endtask

    task automatic test_register;
        @(negedge clk);
        op_sel = 2'd0; pc_in = 16'h0100; step = 1'b1;
        @(posedge clk); #1;
        chk("R9 load on step", pc_q, 16'h0102);
        @(negedge clk);
        step = 1'b0; pc_in = 16'h4000;
        @(posedge clk); #1;
        chk("R9 hold without step", pc_q, 16'h0102);
        @(negedge clk);
        op_sel = 2'd2; pc_in = 16'h2000; rel_off = 11'h010; step = 1'b1;
        @(posedge clk); #1;
        chk("R9 load jump target", pc_q, 16'h2010);
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_sequential();
        test_equality();
        test_signed();
        test_unsigned();
        test_bits();
        test_skip_flags();
        test_immediate();
        test_jump();
        test_wrap();
        test_register();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule